// File: doc/BRIEF.md
# DVMA Page-Table Walk Translator

This block turns 32-bit device DMA virtual addresses into physical addresses of up to 43 bits. Each request is resolved by one read of an 8-byte entry from a linear translation table in memory. Software programs two registers through a small write port: a control word that turns translation on, picks the page size and picks the table size, and the table base address. The block then serves one request at a time. It checks the address against the translation window at the top of the 32-bit space, computes the table slot, fetches the entry, validates it and returns the physical address with its cacheable and streamable attributes, or a fault code.

All four ports use valid/ready handshakes. Only one walk is in flight at a time: a new request is held off until the previous response has been accepted. With translation disabled, addresses pass straight through and no memory read is issued.

Top module: `dvma_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the control word is all zero, so the first request is passed through untranslated.
- R2: With control bit 0 clear, the response carries `rsp_pa` = the virtual address zero-extended to 43 bits, fault 0 and both attributes 0, and no memory read is issued.
- R3: With control bit 2 clear (8K pages) and table-size code n in control bits 18:16, the window base is 2^32 - (8MB << n). An address below the base returns fault code 1 without a memory read.
- R4: The entry address is {table_base[42:13], 13'b0} + ((va - base) >> s) * 8, with s = 13 for 8K pages and s = 16 when control bit 2 is set. In 64K mode the window is 64MB << n bytes and covers the whole 32-bit space when that reaches 4GB.
- R5: A fetched entry with bit 63 clear returns fault code 2, with `rsp_pa` and both attributes 0.
- R6: A request with `req_write` = 1 whose valid entry has bit 1 clear returns fault code 3, with `rsp_pa` and both attributes 0. A read of the same entry succeeds.
- R7: For a valid, permitted entry, `rsp_pa` = {entry[42:13], va[12:0]} when entry bit 61 is 0, and {entry[42:16], va[15:0]} when bit 61 is 1.
- R8: On success, `rsp_cacheable` equals entry bit 4 and `rsp_streamable` equals entry bit 60.
- R9: From acceptance of a request until its response is accepted, `req_ready` is 0. A response or memory read held without ready keeps its valid and payload stable.
- R10: A register write at offset 0x0 sets the control word and one at offset 0x8 sets the table base. A write accepted while a walk is in flight, or in the same cycle as a request, applies only to later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Register write strobe |
| cfg_ready | output | 1 | Register write accepted (always 1) |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translation request accepted |
| req_va | input | 32 | DMA virtual address |
| req_write | input | 1 | 1 for a write access |
| mem_req_valid | output | 1 | Entry fetch request valid |
| mem_req_ready | input | 1 | Entry fetch request accepted |
| mem_req_addr | output | 43 | Entry physical address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_ready | output | 1 | Entry data accepted |
| mem_rsp_data | input | 64 | Fetched translation entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Translation result accepted |
| rsp_pa | output | 43 | Physical address |
| rsp_cacheable | output | 1 | Page is cacheable |
| rsp_streamable | output | 1 | Page is streamable |
| rsp_fault | output | 2 | 0 ok, 1 outside window, 2 invalid entry, 3 write to read-only |

## Verification
The bench aims at the window edges for the smallest and largest table codes, one address on each side of each base. An off-by-one base comparison would either fetch an entry for an address outside the window or fault on the first slot. It drives 64K-page mode at table sizes where the window covers the whole address space. A design that lets the base wrap would fault there, and one that shifts by 13 would fetch from the wrong slot. It mixes 8K and 64K entries, read-only entries under reads and writes, and invalid entries. Swapped offset widths, a fault that leaks the physical page, or a write check applied to reads each give a wrong `rsp_pa` or fault code. It also rewrites both registers in the middle of a walk and stalls every handshake at random, which catches a design that reads the live registers during the walk or lets a held payload change.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_RANGE   = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_st_e;

    // Bit positions inside a translation entry.
    localparam int E_VALID  = 63;
    localparam int E_BIG    = 61;
    localparam int E_STREAM = 60;
    localparam int E_CACHE  = 4;
    localparam int E_WRITE  = 1;

    // Control word fields.
    localparam int C_ENABLE   = 0;
    localparam int C_BIGPAGE  = 2;
    localparam int C_SIZE_LO  = 16;
    localparam int C_SIZE_W   = 3;
endpackage

// File: rtl/dvma_cfg_regs.sv
module dvma_cfg_regs #(
    parameter int CFG_AW   = 4,
    parameter int DATA_W   = 64,
    parameter int PA_W     = 43,
    parameter int PG_SMALL = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CFG_AW-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     ctl_enable,
    output logic                     ctl_bigpage,
    output logic [2:0]               ctl_size,
    output logic [PA_W-PG_SMALL-1:0] tbase_pg
);
    import dvma_pkg::*;

    localparam int TB_W = PA_W - PG_SMALL;
    localparam logic [CFG_AW-1:0] OFS_CTL  = CFG_AW'(0);
    localparam logic [CFG_AW-1:0] OFS_BASE = CFG_AW'(8);

    typedef struct packed {
        logic            en;
        logic            big;
        logic [2:0]      size;
        logic [TB_W-1:0] tb;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && wr_addr == OFS_CTL) begin
            r_d.en   = wr_data[C_ENABLE];
            r_d.big  = wr_data[C_BIGPAGE];
            r_d.size = wr_data[C_SIZE_LO +: C_SIZE_W];
        end
        if (wr_en && wr_addr == OFS_BASE) begin
            r_d.tb = wr_data[PA_W-1:PG_SMALL];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctl_enable  = r_q.en;
    assign ctl_bigpage = r_q.big;
    assign ctl_size    = r_q.size;
    assign tbase_pg    = r_q.tb;

    // R10: control only changes through a write at its own offset
    a_r10_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_CTL) |=> $stable({ctl_enable, ctl_bigpage, ctl_size}));
    // R10: table base only changes through a write at its own offset
    a_r10_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_BASE) |=> $stable(tbase_pg));
endmodule

// File: rtl/dvma_window.sv
module dvma_window #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 43,
    parameter int PG_SMALL     = 13,
    parameter int PG_LARGE     = 16,
    parameter int TBL_MIN_LOG2 = 10,
    parameter int ENT_LOG2     = 3
) (
    input  logic [2:0]               size_code,
    input  logic                     bigpage,
    input  logic [VA_W-1:0]          va,
    input  logic [PA_W-PG_SMALL-1:0] tbase_pg,
    output logic                     in_window,
    output logic [PA_W-1:0]          ent_addr
);
    localparam int SH_W = 6;

    logic [SH_W-1:0] pg_shift;
    logic [SH_W-1:0] win_log2;
    logic [VA_W-1:0] win_base;
    logic [VA_W-1:0] offset;
    logic [VA_W-1:0] slot;

    always_comb begin
        pg_shift  = bigpage ? SH_W'(PG_LARGE) : SH_W'(PG_SMALL);
        win_log2  = SH_W'(TBL_MIN_LOG2) + SH_W'(size_code) + pg_shift;
        // A window of 2^VA_W bytes or more starts at address zero.
        if (int'(win_log2) >= VA_W) win_base = '0;
        else                        win_base = {VA_W{1'b1}} << win_log2;
        in_window = (va >= win_base);
        offset    = va - win_base;
        slot      = offset >> pg_shift;
        ent_addr  = {tbase_pg, {PG_SMALL{1'b0}}} + (PA_W'(slot) << ENT_LOG2);
    end
endmodule

// File: rtl/dvma_entry_check.sv
module dvma_entry_check #(
    parameter int VA_W     = 32,
    parameter int PA_W     = 43,
    parameter int ENT_W    = 64,
    parameter int PG_SMALL = 13,
    parameter int PG_LARGE = 16
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic [VA_W-1:0]   va,
    input  logic              is_write,
    output logic [PA_W-1:0]   pa,
    output logic              cacheable,
    output logic              streamable,
    output dvma_pkg::fault_e  fault
);
    import dvma_pkg::*;

    logic [PA_W-1:0] pa_small, pa_big;

    assign pa_small = {entry[PA_W-1:PG_SMALL], va[PG_SMALL-1:0]};
    assign pa_big   = {entry[PA_W-1:PG_LARGE], va[PG_LARGE-1:0]};

    always_comb begin
        pa         = '0;
        cacheable  = 1'b0;
        streamable = 1'b0;
        if (!entry[E_VALID]) begin
            fault = FLT_INVALID;
        end else if (is_write && !entry[E_WRITE]) begin
            fault = FLT_WPROT;
        end else begin
            fault      = FLT_NONE;
            pa         = entry[E_BIG] ? pa_big : pa_small;
            cacheable  = entry[E_CACHE];
            streamable = entry[E_STREAM];
        end
    end
endmodule

// File: rtl/dvma_walker.sv
module dvma_walker #(
    parameter int VA_W         = 32,
    parameter int PA_W         = 43,
    parameter int ENT_W        = 64,
    parameter int CFG_AW       = 4,
    parameter int PG_SMALL     = 13,
    parameter int PG_LARGE     = 16,
    parameter int TBL_MIN_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ENT_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_cacheable,
    output logic              rsp_streamable,
    output logic [1:0]        rsp_fault
);
    import dvma_pkg::*;

    localparam int TB_W     = PA_W - PG_SMALL;
    localparam int ENT_LOG2 = $clog2(ENT_W / 8);

    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic            wr;
        logic            en;
        logic [PA_W-1:0] addr;
        logic [PA_W-1:0] pa;
        logic            c;
        logic            s;
        fault_e          flt;
    } walk_t;

    walk_t w_d, w_q;

    logic            ctl_enable, ctl_bigpage;
    logic [2:0]      ctl_size;
    logic [TB_W-1:0] tbase_pg;
    logic            win_hit;
    logic [PA_W-1:0] win_addr;
    logic [PA_W-1:0] chk_pa;
    logic            chk_c, chk_s;
    fault_e          chk_flt;

    dvma_cfg_regs #(
        .CFG_AW(CFG_AW), .DATA_W(ENT_W), .PA_W(PA_W), .PG_SMALL(PG_SMALL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_valid), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .ctl_enable(ctl_enable), .ctl_bigpage(ctl_bigpage),
        .ctl_size(ctl_size), .tbase_pg(tbase_pg)
    );

    dvma_window #(
        .VA_W(VA_W), .PA_W(PA_W), .PG_SMALL(PG_SMALL), .PG_LARGE(PG_LARGE),
        .TBL_MIN_LOG2(TBL_MIN_LOG2), .ENT_LOG2(ENT_LOG2)
    ) u_window (
        .size_code(ctl_size), .bigpage(ctl_bigpage), .va(req_va),
        .tbase_pg(tbase_pg), .in_window(win_hit), .ent_addr(win_addr)
    );

    dvma_entry_check #(
        .VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W),
        .PG_SMALL(PG_SMALL), .PG_LARGE(PG_LARGE)
    ) u_check (
        .entry(mem_rsp_data), .va(w_q.va), .is_write(w_q.wr),
        .pa(chk_pa), .cacheable(chk_c), .streamable(chk_s), .fault(chk_flt)
    );

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.va  = req_va;
                    w_d.wr  = req_write;
                    w_d.en  = ctl_enable;
                    w_d.c   = 1'b0;
                    w_d.s   = 1'b0;
                    w_d.flt = FLT_NONE;
                    w_d.pa  = '0;
                    if (!ctl_enable) begin
                        w_d.pa = PA_W'(req_va);
                        w_d.st = ST_RESP;
                    end else if (!win_hit) begin
                        w_d.flt = FLT_RANGE;
                        w_d.st  = ST_RESP;
                    end else begin
                        w_d.addr = win_addr;
                        w_d.st   = ST_FETCH;
                    end
                end
            end
            ST_FETCH: if (mem_req_ready) w_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.pa  = chk_pa;
                    w_d.c   = chk_c;
                    w_d.s   = chk_s;
                    w_d.flt = chk_flt;
                    w_d.st  = ST_RESP;
                end
            end
            ST_RESP: if (rsp_ready) w_d.st = ST_IDLE;
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: ST_IDLE, flt: FLT_NONE, default: '0};
        else        w_q <= w_d;
    end

    assign cfg_ready      = 1'b1;
    assign req_ready      = (w_q.st == ST_IDLE);
    assign mem_req_valid  = (w_q.st == ST_FETCH);
    assign mem_req_addr   = w_q.addr;
    assign mem_rsp_ready  = (w_q.st == ST_WAIT);
    assign rsp_valid      = (w_q.st == ST_RESP);
    assign rsp_pa         = w_q.pa;
    assign rsp_cacheable  = w_q.c;
    assign rsp_streamable = w_q.s;
    assign rsp_fault      = w_q.flt;

    // R9: a held response keeps its payload
    a_r9_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)
            && $stable(rsp_cacheable) && $stable(rsp_streamable));
    // R9: a held fetch keeps its address
    a_r9_fetch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R4: fetches are entry aligned
    a_r4_entry_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[ENT_LOG2-1:0] == '0);
    // R2: no table access for a request taken with translation off
    a_r2_no_fetch_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> w_q.en);
    // R7: the page offset of a good translation is the request's
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault == FLT_NONE |-> rsp_pa[PG_SMALL-1:0] == w_q.va[PG_SMALL-1:0]);
endmodule

// File: tb/dvma_walker_bench.sv
module dvma_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0, cfg_ready;
    logic [3:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [31:0] req_va = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [42:0] mem_req_addr;
    logic        mem_rsp_valid, mem_rsp_ready;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid, rsp_ready = 1'b0;
    logic [42:0] rsp_pa;
    logic        rsp_cacheable, rsp_streamable;
    logic [1:0]  rsp_fault;

    int checks = 0, fails = 0, fetches = 0;
    logic [42:0] cap_addr;
    logic [31:0] key = 32'h1234_5678;
    logic        force_en = 1'b0;
    logic [63:0] force_val = '0;
    logic [63:0] ctl_m = '0, tb_m = '0;

    always #2 clk = ~clk;

    dvma_walker u_dvma_walker (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa),
        .rsp_cacheable(rsp_cacheable), .rsp_streamable(rsp_streamable), .rsp_fault(rsp_fault)
    );

    task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [42:0] a);
        logic [63:0] h;
        if (force_en) return force_val;
        h = ({21'b0, a} ^ {key, 32'h0}) * 64'h9E37_79B9_7F4A_7C15;
        h = h ^ (h >> 29);
        return h;
    endfunction

    function automatic void model(input logic [63:0] ctl, input logic [63:0] tb, input logic [31:0] va,
                                  input logic wr, output logic fetch, output logic [42:0] addr,
                                  output logic [1:0] flt, output logic [42:0] pa,
                                  output logic c, output logic s);
        int sh, wb;
        logic [63:0] base, e;
        fetch = 0; addr = '0; flt = 0; pa = '0; c = 0; s = 0;
        if (!ctl[0]) begin
            pa = {11'b0, va};
            return;
        end
        sh = ctl[2] ? 16 : 13;
        wb = 10 + int'(ctl[18:16]) + sh;
        base = (wb >= 32) ? 64'd0 : (64'h1_0000_0000 - (64'd1 << wb));
        if ({32'b0, va} < base) begin
            flt = 1;
            return;
        end
        fetch = 1;
        addr = 43'({tb[42:13], 13'b0} + ((({32'b0, va} - base) >> sh) << 3));
        e = entry_of(addr);
        if (!e[63]) flt = 2;
        else if (wr && !e[1]) flt = 3;
        else begin
            pa = e[61] ? {e[42:16], va[15:0]} : {e[42:13], va[12:0]};
            c = e[4];
            s = e[60];
        end
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_valid = 0;
        if (a == 4'h0) ctl_m = d;
        if (a == 4'h8) tb_m = d;
    endtask

    // Memory responder with random stalls.
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                repeat ($urandom % 3) @(negedge clk);
                mem_req_ready = 1;
                cap_addr = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 0;
                fetches++;
                repeat (1 + $urandom % 3) @(negedge clk);
                mem_rsp_data = entry_of(cap_addr);
                mem_rsp_valid = 1;
                @(negedge clk);
                mem_rsp_valid = 0;
            end
        end
    end

    // One translation; optional register write while the walk is in flight (R10).
    task automatic xlate(input logic [31:0] va, input logic wr, input string tag,
                         input logic mid_wr = 0, input logic [3:0] mid_a = 0, input logic [63:0] mid_d = 0);
        logic ef, ec, es;
        logic [42:0] ea, epa, pa0;
        logic [1:0] eflt, f0;
        int f_before;
        model(ctl_m, tb_m, va, wr, ef, ea, eflt, epa, ec, es);
        f_before = fetches;
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, {tag, " R9 req_ready low during walk"}, req_ready, 0);
        if (mid_wr) begin
            cfg_valid = 1; cfg_addr = mid_a; cfg_wdata = mid_d;
            @(negedge clk);
            cfg_valid = 0;
            if (mid_a == 4'h0) ctl_m = mid_d;
            if (mid_a == 4'h8) tb_m = mid_d;
        end
        while (!rsp_valid) @(negedge clk);
        pa0 = rsp_pa; f0 = rsp_fault;
        repeat ($urandom % 3) begin
            @(negedge clk);
            chk(rsp_valid && rsp_pa == pa0 && rsp_fault == f0, {tag, " R9 held response stable"}, rsp_pa, pa0);
        end
        chk(rsp_fault == eflt, {tag, " fault code"}, rsp_fault, eflt);
        chk(rsp_pa == epa, {tag, " physical address"}, rsp_pa, epa);
        chk(rsp_cacheable == ec && rsp_streamable == es, {tag, " R8 attributes"},
            {rsp_cacheable, rsp_streamable}, {ec, es});
        chk((fetches - f_before) == int'(ef), {tag, " fetch count"}, fetches - f_before, ef);
        if (ef) chk(cap_addr == ea, {tag, " R4 entry address"}, cap_addr, ea);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset handshake state",
            {req_ready, rsp_valid, mem_req_valid}, 3'b100);
        xlate(32'hDEAD_BEEF, 1, "R1 control zero after reset");
        xlate(32'h0000_1234, 0, "R2 bypass low");

        cfg_write(4'h8, 64'h0000_0123_4567_E000);
        cfg_write(4'h0, 64'h0000_0000_0000_0001);           // n=0, 8K
        force_en = 1; force_val = 64'h9000_0000_0000_0012 | (64'h0ABC_DE12 << 13);
        xlate(32'hFF80_0000, 1, "R3 first slot n0");
        xlate(32'hFF7F_FFFF, 0, "R3 just below base n0");
        xlate(32'hFFFF_FFFF, 0, "R7 last slot n0");
        cfg_write(4'h0, 64'h0000_0000_0007_0001);           // n=7, 8K
        xlate(32'hC000_0000, 0, "R3 base n7");
        xlate(32'hBFFF_FFFF, 0, "R3 below base n7");
        cfg_write(4'h0, 64'h0000_0000_0006_0005);           // n=6, 64K: whole space
        xlate(32'h0000_0000, 0, "R4 64K full window bottom");
        xlate(32'hFFFF_FFFF, 0, "R4 64K full window top");
        cfg_write(4'h0, 64'h0000_0000_0002_0005);           // n=2, 64K
        xlate(32'hEFFF_FFFF, 0, "R4 64K below base");
        force_val = 64'hA000_0000_0000_0012 | (64'h3_1111 << 16);
        xlate(32'hF123_4567, 0, "R7 big entry");
        force_val = 64'h1000_0000_0000_0012;
        xlate(32'hF000_0000, 0, "R5 invalid entry");
        force_val = 64'h8000_0000_0000_0010 | (64'h55 << 13);
        xlate(32'hF000_2000, 1, "R6 write read-only");
        xlate(32'hF000_2000, 0, "R6 read read-only");
        force_val = 64'h9000_0000_0000_0002;
        xlate(32'hF000_4000, 0, "R8 stream no cache");

        force_en = 0;
        cfg_write(4'h0, 64'h0000_0000_0003_0001);
        xlate(32'hFE00_8000, 0, "R10 walk with base write", 1, 4'h8, 64'h0000_0400_0000_2000);
        xlate(32'hFE00_8000, 0, "R10 new base used");
        xlate(32'hFE00_8000, 0, "R10 walk with ctl write", 1, 4'h0, 64'h0);
        xlate(32'hFE00_8000, 0, "R10 R2 disabled after write");
        cfg_write(4'h4, 64'hFFFF_FFFF_FFFF_FFFF);
        xlate(32'h0000_8000, 0, "R10 other offset ignored");

        for (int i = 0; i < 300; i++) begin
            logic [63:0] c;
            logic [31:0] va;
            key = $urandom;
            c = {45'b0, 3'($urandom), 13'b0, 1'($urandom), 1'($urandom), ($urandom % 8) != 0};
            if ($urandom % 4 == 0)
                cfg_write(4'h8, {21'b0, 30'($urandom) , 13'($urandom)});
            cfg_write(4'h0, c);
            va = ($urandom % 5 == 0) ? $urandom : (32'hFFFF_FFFF - ($urandom % (32'h0080_0000 << c[18:16])));
            xlate(va, 1'($urandom), "R7 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule